// File: doc/BRIEF.md
# Region-Aware Byte Checksum Accumulator

This block keeps a 16-bit running checksum over a stream of memory words taken from a device image. Each word arrives with a one-bit region tag. A program-memory word is 24 bits wide, and each of its three bytes is added. A configuration or identification register holds only 16 bits of real data. For such a word the two low bytes are added and the top byte is dropped. The block adds bytes, not whole words, and the total wraps at 16 bits.

A source hands words over with a valid/ready handshake, one word per clock. All bytes of an accepted word are summed in that same cycle. The source marks the final word with an end-of-stream flag. One cycle later the block shows the finished checksum and raises done for a single cycle. After that it holds the result and refuses further words until a clear. Pulsing clear sets the total back to zero and starts a new stream. The block has no view of addresses or protection settings. It sums exactly the words it is given, and register-tagged words are always accepted like any other.

Top module: `image_checksum`

## Requirements
- R1: After reset, sumOut is 0, doneOut is 0 and inReady is 1.
- R2: A word accepted with inTag = 0 (program region) adds inData[7:0] + inData[15:8] + inData[23:16] to the total.
- R3: A word accepted with inTag = 1 (register region) adds inData[7:0] + inData[15:8] only; inData[23:16] has no effect on the total.
- R4: The total is kept modulo 2^16; carries out of bit 15 are discarded.
- R5: A word is accepted on a rising edge where inValid and inReady are both 1. The new total appears on sumOut after that edge, so back-to-back words are summed at one per cycle. A cycle without acceptance leaves sumOut unchanged.
- R6: While clearIn is 1, inReady is 0. After an edge that samples clearIn = 1, sumOut is 0, doneOut is 0 and inReady returns to 1 once clearIn falls.
- R7: After the edge that accepts a word with inLast = 1, doneOut is 1 for exactly one cycle. In that cycle sumOut already includes that last word.
- R8: After a word with inLast = 1 is accepted, inReady stays 0 and sumOut stays constant until a clear. Words offered in that time are not added.
- R9: For a stream that mixes both region tags in random order, the final sumOut equals the bytewise reference sum modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| clearIn | input | 1 | Zero the total and start a new stream |
| inValid | input | 1 | Input word is valid |
| inReady | output | 1 | Block can accept a word |
| inData | input | 24 | Memory word |
| inTag | input | 1 | Region: 0 = program (3 bytes), 1 = register (2 bytes) |
| inLast | input | 1 | Marks the final word of the stream |
| sumOut | output | 16 | Running or final checksum |
| doneOut | output | 1 | One-cycle pulse when the final sum is shown |

## Verification
Single program words with different bytes in each lane show whether all three lanes are added. Register words that carry 0xFF in the top byte show whether that lane is masked. A long run of all-ones program words pushes the total through several wraps, which exposes any carry kept past bit 15. Gapped and back-to-back streams, then words offered after the end marker and clears in mid-stream, separate correct handshake handling from adds that were dropped or counted twice. A random mix of both tags is compared with a reference byte sum.

// File: rtl/image_checksum_pkg.sv
package image_checksum_pkg;
  typedef enum logic {
    TAG_PROG = 1'b0,
    TAG_REG  = 1'b1
  } regionTag_t;

  typedef struct packed {
    logic clr;
    logic add;
    logic fin;
  } ctrlStrobe_t;
endpackage

// File: rtl/image_checksum_ctrl.sv
module image_checksum_ctrl
  import image_checksum_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clearIn,
  input  logic        inValid,
  input  logic        inLast,
  output logic        inReady,
  output ctrlStrobe_t strobe
);
  typedef enum logic {ST_RUN, ST_HOLD} state_t;
  state_t state;

  assign inReady    = (state == ST_RUN) && !clearIn;
  assign strobe.clr = clearIn;
  assign strobe.add = inValid && inReady;
  assign strobe.fin = inValid && inReady && inLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               state <= ST_RUN;
    else if (clearIn)        state <= ST_RUN;
    else if (strobe.fin)     state <= ST_HOLD;
  end

  // R8: once held, only a clear reopens the input
  assert_hold_until_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !clearIn) |=> (state == ST_HOLD));
  // R6: clear always blocks acceptance
  assert_clear_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |-> !strobe.add);
endmodule

// File: rtl/image_checksum_dp.sv
module image_checksum_dp
  import image_checksum_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int PROG_BYTES = 3,
  parameter int REG_BYTES  = 2,
  parameter int SUM_W      = 16,
  localparam int DATA_W    = BYTE_W * PROG_BYTES
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic              inTag,
  output logic [SUM_W-1:0]  sumOut,
  output logic              doneOut
);
  logic [SUM_W-1:0] laneVal [PROG_BYTES];
  logic [SUM_W-1:0] addend;
  logic             isReg;

  assign isReg = (inTag == TAG_REG);

  for (genvar g = 0; g < PROG_BYTES; g++) begin : gLane
    logic laneEn;
    if (g < REG_BYTES) begin : gAlways
      assign laneEn = 1'b1;
    end else begin : gProgOnly
      assign laneEn = !isReg;
    end
    assign laneVal[g] = laneEn ? SUM_W'(inData[g*BYTE_W +: BYTE_W]) : '0;
  end

  always_comb begin
    addend = '0;
    for (int i = 0; i < PROG_BYTES; i++) addend = addend + laneVal[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumOut  <= '0;
      doneOut <= 1'b0;
    end else if (strobe.clr) begin
      sumOut  <= '0;
      doneOut <= 1'b0;
    end else begin
      if (strobe.add) sumOut <= sumOut + addend;
      doneOut <= strobe.fin;
    end
  end

  // R3: a register word raises the total by at most two bytes' worth
  assert_reg_two_bytes_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.add && isReg && !strobe.clr) |=>
      (SUM_W'(sumOut - $past(sumOut)) <= SUM_W'(REG_BYTES * ((1 << BYTE_W) - 1))));
  // R7: done is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);
endmodule

// File: rtl/image_checksum.sv
module image_checksum
  import image_checksum_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int PROG_BYTES = 3,
  parameter int REG_BYTES  = 2,
  parameter int SUM_W      = 16,
  localparam int DATA_W    = BYTE_W * PROG_BYTES
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearIn,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inTag,
  input  logic              inLast,
  output logic [SUM_W-1:0]  sumOut,
  output logic              doneOut
);
  ctrlStrobe_t strobe;

  image_checksum_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .inValid(inValid),
    .inLast(inLast), .inReady(inReady), .strobe(strobe)
  );

  image_checksum_dp #(
    .BYTE_W(BYTE_W), .PROG_BYTES(PROG_BYTES), .REG_BYTES(REG_BYTES), .SUM_W(SUM_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData), .inTag(inTag),
    .sumOut(sumOut), .doneOut(doneOut)
  );

  // R5: no accepted word and no clear means the total stays put
  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!(inValid && inReady) && !clearIn) |=> $stable(sumOut));
  // R6: a sampled clear zeroes the total
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> (sumOut == '0 && !doneOut));
  // R8: while done is shown, no word can enter
  assert_done_not_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !inReady);
endmodule

// File: tb/tb_image_checksum.sv
module tb_image_checksum;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clearIn = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [23:0] inData = '0;
  logic        inTag = 1'b0;
  logic        inLast = 1'b0;
  logic [15:0] sumOut;
  logic        doneOut;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 0;
  logic [15:0] refSum;

  always #(CLK_PERIOD/2) clk = ~clk;

  image_checksum dut (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .inValid(inValid),
    .inReady(inReady), .inData(inData), .inTag(inTag), .inLast(inLast),
    .sumOut(sumOut), .doneOut(doneOut)
  );

  function automatic logic [15:0] refAdd(logic [15:0] s, logic [23:0] d, logic t);
    logic [15:0] r;
    r = s + 16'(d[7:0]) + 16'(d[15:8]);
    if (!t) r = r + 16'(d[23:16]);
    return r;
  endfunction

  task automatic checkEq(string req, logic [31:0] act, logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // inputs change at negedge; outputs are read at the following negedge
  task automatic offer(logic [23:0] d, logic t, logic l);
    inValid = 1'b1; inData = d; inTag = t; inLast = l;
    @(negedge clk);
  endtask

  task automatic idle();
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic doClear();
    clearIn = 1'b1;
    #1 checkEq("R6 ready low during clear", 32'(inReady), 0);
    @(negedge clk);
    clearIn = 1'b0;
    #1;
    checkEq("R6 sum zero after clear", 32'(sumOut), 0);
    checkEq("R6 ready back after clear", 32'(inReady), 1);
    refSum = '0;
  endtask

  task automatic testReset();
    checkEq("R1 sum at reset", 32'(sumOut), 0);
    checkEq("R1 done at reset", 32'(doneOut), 0);
    checkEq("R1 ready at reset", 32'(inReady), 1);
  endtask

  task automatic testProgram();
    doClear();
    offer(24'h030201, 1'b0, 1'b0); idle();
    checkEq("R2 program word three bytes", 32'(sumOut), 6);
    offer(24'hFF8040, 1'b0, 1'b0); idle();
    checkEq("R2 second program word", 32'(sumOut), 6 + 32'h1BF);
  endtask

  task automatic testRegister();
    doClear();
    offer(24'hFF1020, 1'b1, 1'b0); idle();
    checkEq("R3 register upper byte ignored", 32'(sumOut), 32'h30);
    offer(24'hAB0000, 1'b1, 1'b0); idle();
    checkEq("R3 only upper byte set adds nothing", 32'(sumOut), 32'h30);
  endtask

  task automatic testWrap();
    doClear();
    for (int i = 0; i < 100; i++) offer(24'hFFFFFF, 1'b0, 1'b0);
    idle();
    checkEq("R4 wrap modulo 2^16", 32'(sumOut), (100 * 765) % 65536);
  endtask

  task automatic testHandshake();
    doClear();
    offer(24'h000005, 1'b0, 1'b0);
    checkEq("R5 back-to-back first", 32'(sumOut), 5);
    offer(24'h000007, 1'b1, 1'b0);
    checkEq("R5 back-to-back second", 32'(sumOut), 12);
    idle(); inData = 24'h0F0F0F;
    @(negedge clk);
    checkEq("R5 no valid no add", 32'(sumOut), 12);
    @(negedge clk);
    checkEq("R5 still unchanged", 32'(sumOut), 12);
  endtask

  task automatic testLastHold();
    doClear();
    offer(24'h010101, 1'b0, 1'b0);
    checkEq("R7 no done before last", 32'(doneOut), 0);
    offer(24'h000102, 1'b1, 1'b1); idle();
    checkEq("R7 done after last", 32'(doneOut), 1);
    checkEq("R7 final sum includes last", 32'(sumOut), 6);
    checkEq("R8 ready low after last", 32'(inReady), 0);
    offer(24'h111111, 1'b0, 1'b0);
    checkEq("R7 done single pulse", 32'(doneOut), 0);
    offer(24'h222222, 1'b0, 1'b1); idle();
    checkEq("R8 words after end ignored", 32'(sumOut), 6);
    checkEq("R8 no second done", 32'(doneOut), 0);
    doClear();
    checkEq("R6 done low after clear", 32'(doneOut), 0);
    offer(24'h000009, 1'b1, 1'b0); idle();
    checkEq("R6 new stream after clear", 32'(sumOut), 9);
  endtask

  task automatic testMidClear();
    doClear();
    offer(24'h123456, 1'b0, 1'b0); idle();
    doClear();
    offer(24'h000003, 1'b0, 1'b0); idle();
    checkEq("R6 mid-stream clear restarts", 32'(sumOut), 3);
  endtask

  task automatic testRandom(int n);
    logic [23:0] d;
    logic t;
    doClear();
    for (int i = 0; i < n; i++) begin
      d = 24'($urandom);
      t = 1'($urandom);
      refSum = refAdd(refSum, d, t);
      offer(d, t, (i == n - 1));
      if (($urandom % 4) == 0 && i != n - 1) begin
        idle();
        @(negedge clk);
      end
    end
    idle();
    checkEq("R9 random mixed stream sum", 32'(sumOut), 32'(refSum));
    checkEq("R9 random stream done", 32'(doneOut), 1);
  endtask

  initial begin
    refSum = '0;
    #(CLK_PERIOD * 2 + 2);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testProgram();
    testRegister();
    testWrap();
    testHandshake();
    testLastHold();
    testMidClear();
    testRandom(300);
    testRandom(57);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end
endmodule